// File: doc/BRIEF.md
# Interleaved Multithread Context Sequencer

This block picks which hardware context feeds a barrel-style pipeline on each clock. It keeps a program counter and two flags per context: one for whether the context is running, and one for whether it is parked on a long-latency memory access. It walks the contexts in a fixed rotation, one slot per clock. Every cycle it presents a bundle made of a valid bit, the slot's context id and that context's PC. The context id also selects the context's register-file bank downstream.

The rotation never waits. A context that is not running, or that is parked, still gets its slot, but the slot goes out as a bubble with valid low. The other contexts therefore keep their exact spacing. The integrator sets the context count to at least the pipeline depth. A context's next PC then comes back through the writeback port before its next slot, and neighbouring slots never depend on each other. For this reason the block has no interlock output and no bypass logic.

After reset, context 0 runs from the reset vector and every other context is idle. Software or a control unit starts an idle context with a start command that carries a context id and a PC. Stall and resume commands, each tagged with a context id, park a context and release it.

Top module: `ctx_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, the slot context is 0 with valid high and PC equal to RESET_PC. Every other context is idle, and every stored PC equals RESET_PC.
- R2: The slot context id advances by one each cycle and wraps from NCTX-1 to 0, whether or not the slot is valid.
- R3: A slot's valid bit is high only when its context is running and not parked. Otherwise the slot is a bubble with valid low.
- R4: The slot PC is the PC stored for the slot's context.
- R5: A writeback (wb_vld high) replaces only the tagged context's PC, with effect from the next cycle. A writeback to an idle context is ignored.
- R6: A start command makes the tagged context running, clears its parked flag and loads its PC, with effect from the next cycle. A start wins over a writeback to the same context in the same cycle.
- R7: A stall command parks the tagged context and a resume command releases it. When both name the same context in the same cycle, the resume wins.
- R8: Two consecutive slots always carry different context ids (NCTX at least 2), and no stall is ever applied to the rotation itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_vld | input | 1 | Start command strobe |
| start_ctx | input | CW | Context to start |
| start_pc | input | PC_W | First PC of the started context |
| wb_vld | input | 1 | Next-PC writeback strobe from the last pipeline stage |
| wb_ctx | input | CW | Context the writeback belongs to |
| wb_pc | input | PC_W | Next PC for that context |
| stall_vld | input | 1 | Park strobe for a long-latency access |
| stall_ctx | input | CW | Context to park |
| resume_vld | input | 1 | Release strobe |
| resume_ctx | input | CW | Context to release |
| iss_vld | output | 1 | Slot carries a real fetch |
| iss_ctx | output | CW | Context id of the slot (also its register bank) |
| iss_pc | output | PC_W | PC of the slot's context |

## Verification
The assertions check on every cycle that the rotation steps by one modulo NCTX and never repeats an id, that a started or resumed context is unparked one cycle later, and that a PC that no start or writeback targets holds its value. They also check that a parked context never produces a valid slot in the cycle after a stall. Only the bench's scenarios can show the fuller picture. These include the exact PC values that reach the pipeline after chains of starts and writebacks, a writeback to an idle context leaving the later slot unchanged, the start-over-writeback and resume-over-stall tie breaks, and a mid-run reset returning every context to its initial state.

// File: rtl/ctxseq_pkg.sv
// Package: shared helpers for the context sequencer.
// Assumes: context counts are at least 1.
package ctxseq_pkg;

    // Width of a context id for a given context count (minimum 1 bit).
    function automatic int idw(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ctx_rotor.sv
// Module: ctx_rotor
// Holds the slot counter and steps it by one modulo NCTX every clock.
// Assumes: NCTX >= 2. Nothing stops the rotation, so the counter never holds.
module ctx_rotor #(
    parameter int NCTX = 4,
    localparam int CW = ctxseq_pkg::idw(NCTX)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cur_q
);

    localparam logic [CW-1:0] LAST = CW'(NCTX - 1);

    // Advance the slot counter with wrap at the last context.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= '0;
        else if (cur_q == LAST)
            cur_q <= '0;
        else
            cur_q <= cur_q + 1'b1;
    end

    // R2
    rot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cur_q == LAST) |=> cur_q == '0);

    // R8
    rot_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cur_q != $past(cur_q));

endmodule

// File: rtl/ctx_state.sv
// Module: ctx_state
// Keeps a running flag and a parked flag per context.
// Tie breaks: start beats resume, and resume beats stall, for the same context.
// Assumes: command ids are below NCTX. Ids outside that range match no context.
module ctx_state #(
    parameter int NCTX = 4,
    localparam int CW = ctxseq_pkg::idw(NCTX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_vld,
    input  logic [CW-1:0]   start_ctx,
    input  logic            stall_vld,
    input  logic [CW-1:0]   stall_ctx,
    input  logic            resume_vld,
    input  logic [CW-1:0]   resume_ctx,
    output logic [NCTX-1:0] act_q,
    output logic [NCTX-1:0] park_q
);

    for (genvar i = 0; i < NCTX; i++) begin : g_ctx
        logic hit_start, hit_stall, hit_resume;

        // Decode which commands name this context.
        always_comb begin
            hit_start  = start_vld  && (start_ctx  == CW'(i));
            hit_stall  = stall_vld  && (stall_ctx  == CW'(i));
            hit_resume = resume_vld && (resume_ctx == CW'(i));
        end

        // Running flag: context 0 runs from reset, the others wait for a start.
        always_ff @(posedge clk) begin
            if (!rst_n)
                act_q[i] <= (i == 0);
            else if (hit_start)
                act_q[i] <= 1'b1;
        end

        // Parked flag: cleared by start or resume, set by stall.
        always_ff @(posedge clk) begin
            if (!rst_n)
                park_q[i] <= 1'b0;
            else if (hit_start || hit_resume)
                park_q[i] <= 1'b0;
            else if (hit_stall)
                park_q[i] <= 1'b1;
        end

        // R6
        start_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_start |=> (act_q[i] && !park_q[i]));

        // R7
        resume_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_resume |=> !park_q[i]);
    end

endmodule

// File: rtl/ctx_pc_bank.sv
// Module: ctx_pc_bank
// Stores one PC per context. A start loads its PC.
// A writeback loads only a running context. Start wins a same-cycle clash.
// Assumes: writeback arrives before the context's next slot (NCTX >= pipe depth).
module ctx_pc_bank #(
    parameter int NCTX = 4,
    parameter int PC_W = 16,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    localparam int CW = ctxseq_pkg::idw(NCTX)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_vld,
    input  logic [CW-1:0]             start_ctx,
    input  logic [PC_W-1:0]           start_pc,
    input  logic                      wb_vld,
    input  logic [CW-1:0]             wb_ctx,
    input  logic [PC_W-1:0]           wb_pc,
    input  logic [NCTX-1:0]           act_q,
    output logic [NCTX-1:0][PC_W-1:0] pc_q
);

    for (genvar i = 0; i < NCTX; i++) begin : g_pc
        logic ld_start, ld_wb;

        // Decode load sources for this context.
        always_comb begin
            ld_start = start_vld && (start_ctx == CW'(i));
            ld_wb    = wb_vld && (wb_ctx == CW'(i)) && act_q[i];
        end

        // PC register with start taking priority over writeback.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pc_q[i] <= RESET_PC;
            else if (ld_start)
                pc_q[i] <= start_pc;
            else if (ld_wb)
                pc_q[i] <= wb_pc;
        end

        // R5
        pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && !(start_vld && start_ctx == CW'(i))
                   && !(wb_vld && wb_ctx == CW'(i))) |=> $stable(pc_q[i]));

        // R6
        start_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (start_vld && start_ctx == CW'(i)) |=> pc_q[i] == $past(start_pc));
    end

endmodule

// File: rtl/ctx_sequencer.sv
// Module: ctx_sequencer (top)
// Rotates over NCTX hardware contexts, one slot per clock. Each slot emits
// {valid, context id, PC}. Idle or parked contexts give a bubble in their slot.
// Assumes: NCTX >= 2 and NCTX >= pipeline depth, so no interlock or bypass
// is needed. The context id doubles as the register bank index downstream.
module ctx_sequencer #(
    parameter int NCTX = 4,
    parameter int PC_W = 16,
    parameter logic [PC_W-1:0] RESET_PC = 16'h0100,
    localparam int CW = ctxseq_pkg::idw(NCTX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_vld,
    input  logic [CW-1:0]   start_ctx,
    input  logic [PC_W-1:0] start_pc,
    input  logic            wb_vld,
    input  logic [CW-1:0]   wb_ctx,
    input  logic [PC_W-1:0] wb_pc,
    input  logic            stall_vld,
    input  logic [CW-1:0]   stall_ctx,
    input  logic            resume_vld,
    input  logic [CW-1:0]   resume_ctx,
    output logic            iss_vld,
    output logic [CW-1:0]   iss_ctx,
    output logic [PC_W-1:0] iss_pc
);

    logic [CW-1:0]             cur_q;
    logic [NCTX-1:0]           act_q;
    logic [NCTX-1:0]           park_q;
    logic [NCTX-1:0][PC_W-1:0] pc_q;

    ctx_rotor #(.NCTX(NCTX)) u_rotor (
        .clk   (clk),
        .rst_n (rst_n),
        .cur_q (cur_q)
    );

    ctx_state #(.NCTX(NCTX)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_vld  (start_vld),
        .start_ctx  (start_ctx),
        .stall_vld  (stall_vld),
        .stall_ctx  (stall_ctx),
        .resume_vld (resume_vld),
        .resume_ctx (resume_ctx),
        .act_q      (act_q),
        .park_q     (park_q)
    );

    ctx_pc_bank #(.NCTX(NCTX), .PC_W(PC_W), .RESET_PC(RESET_PC)) u_pcs (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_vld (start_vld),
        .start_ctx (start_ctx),
        .start_pc  (start_pc),
        .wb_vld    (wb_vld),
        .wb_ctx    (wb_ctx),
        .wb_pc     (wb_pc),
        .act_q     (act_q),
        .pc_q      (pc_q)
    );

    // Slot select: the slot context's flags and PC drive the issue bundle.
    always_comb begin
        iss_ctx = cur_q;
        iss_vld = act_q[cur_q] && !park_q[cur_q];
        iss_pc  = pc_q[cur_q];
    end

    // R3
    stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_vld && !(resume_vld && resume_ctx == stall_ctx)
                   && !(start_vld && start_ctx == stall_ctx))
        |=> !(iss_vld && iss_ctx == $past(stall_ctx)));

    // R1
    reset_slot_chk: assert property (@(posedge clk)
        !rst_n |=> (iss_ctx == '0 && iss_vld && iss_pc == RESET_PC));

endmodule

// File: tb/sim_ctx_sequencer.sv
module sim_ctx_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int NROW = 16;

    typedef struct packed {
        logic        sv; logic [1:0] sc; logic [15:0] sp;
        logic        wv; logic [1:0] wc; logic [15:0] wp;
        logic        tv; logic [1:0] tc;
        logic        rv; logic [1:0] rc;
        logic        ev; logic [1:0] ec; logic [15:0] ep;
        logic [3:0]  rq;
    } row_t;

    // Row k is driven before edge k+1; its expectation is the next slot.
    localparam row_t TBL [NROW] = '{
        '{1,1,16'h0200, 0,0,16'h0, 0,0, 0,0, 1,1,16'h0200, 6}, // R6 start ctx1
        '{0,0,16'h0,    1,1,16'h0204, 0,0, 0,0, 0,2,16'h0100, 3}, // R3 idle ctx2 bubble
        '{0,0,16'h0,    1,0,16'h0104, 0,0, 0,0, 0,3,16'h0100, 3}, // R3 idle ctx3
        '{1,3,16'h0300, 0,0,16'h0, 0,0, 0,0, 1,0,16'h0104, 5}, // R5 wb ctx0 seen
        '{0,0,16'h0,    0,0,16'h0, 1,1, 0,0, 0,1,16'h0204, 7}, // R7 stall ctx1 bubble
        '{0,0,16'h0,    1,2,16'h0555, 0,0, 0,0, 0,2,16'h0100, 5}, // R5 wb to idle ignored
        '{0,0,16'h0,    0,0,16'h0, 0,0, 0,0, 1,3,16'h0300, 6}, // R6 ctx3 started
        '{0,0,16'h0,    0,0,16'h0, 0,0, 1,1, 1,0,16'h0104, 4}, // R4 ctx0 pc
        '{0,0,16'h0,    0,0,16'h0, 0,0, 0,0, 1,1,16'h0204, 7}, // R7 resumed ctx1
        '{1,2,16'h0400, 1,2,16'h0999, 0,0, 0,0, 1,2,16'h0400, 6}, // R6 start beats wb
        '{0,0,16'h0,    0,0,16'h0, 1,3, 1,3, 1,3,16'h0300, 7}, // R7 resume beats stall
        '{0,0,16'h0,    0,0,16'h0, 1,0, 0,0, 0,0,16'h0104, 3}, // R3 parked ctx0
        '{1,0,16'h0180, 0,0,16'h0, 0,0, 0,0, 1,1,16'h0204, 2}, // R2 rotation
        '{0,0,16'h0,    0,0,16'h0, 0,0, 0,0, 1,2,16'h0400, 2}, // R2
        '{0,0,16'h0,    0,0,16'h0, 0,0, 0,0, 1,3,16'h0300, 8}, // R8
        '{0,0,16'h0,    0,0,16'h0, 0,0, 0,0, 1,0,16'h0180, 6}  // R6 start unparks ctx0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_vld = 0, wb_vld = 0, stall_vld = 0, resume_vld = 0;
    logic [1:0]  start_ctx = 0, wb_ctx = 0, stall_ctx = 0, resume_ctx = 0;
    logic [15:0] start_pc = 0, wb_pc = 0;
    logic        iss_vld;
    logic [1:0]  iss_ctx;
    logic [15:0] iss_pc;
    int          checks = 0;
    int          fails = 0;
    logic [1:0]  prev_ctx;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ctx_sequencer #(.NCTX(4), .PC_W(16), .RESET_PC(16'h0100)) u0 (
        .clk(clk), .rst_n(rst_n),
        .start_vld(start_vld), .start_ctx(start_ctx), .start_pc(start_pc),
        .wb_vld(wb_vld), .wb_ctx(wb_ctx), .wb_pc(wb_pc),
        .stall_vld(stall_vld), .stall_ctx(stall_ctx),
        .resume_vld(resume_vld), .resume_ctx(resume_ctx),
        .iss_vld(iss_vld), .iss_ctx(iss_ctx), .iss_pc(iss_pc)
    );

    task automatic chk(input int rq, input logic ev, input logic [1:0] ec,
                       input logic [15:0] ep);
        checks++;
        if (iss_vld !== ev || iss_ctx !== ec || iss_pc !== ep) begin
            fails++;
            $display("FAIL R%0d: got vld=%0b ctx=%0d pc=%h, expected vld=%0b ctx=%0d pc=%h",
                     rq, iss_vld, iss_ctx, iss_pc, ev, ec, ep);
        end
    endtask

    task automatic idle_inputs();
        start_vld = 0; wb_vld = 0; stall_vld = 0; resume_vld = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(1, 1'b1, 2'd0, 16'h0100);            // R1 during reset
        rst_n = 1'b1;
        chk(1, 1'b1, 2'd0, 16'h0100);            // R1 first cycle after reset
        for (int k = 0; k < NROW; k++) begin
            start_vld = TBL[k].sv; start_ctx = TBL[k].sc; start_pc = TBL[k].sp;
            wb_vld = TBL[k].wv; wb_ctx = TBL[k].wc; wb_pc = TBL[k].wp;
            stall_vld = TBL[k].tv; stall_ctx = TBL[k].tc;
            resume_vld = TBL[k].rv; resume_ctx = TBL[k].rc;
            prev_ctx = iss_ctx;
            @(negedge clk);
            chk(int'(TBL[k].rq), TBL[k].ev, TBL[k].ec, TBL[k].ep);
            checks++;                            // R8 consecutive slots differ
            if (iss_ctx == prev_ctx) begin
                fails++;
                $display("FAIL R8: got ctx=%0d, expected not %0d", iss_ctx, prev_ctx);
            end
        end
        idle_inputs();
        // Mid-run reset restores every context (R1).
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(1, 1'b1, 2'd0, 16'h0100);
        @(negedge clk); chk(1, 1'b0, 2'd1, 16'h0100);   // R1 ctx1 idle again
        @(negedge clk); chk(1, 1'b0, 2'd2, 16'h0100);   // R1 ctx2 idle again
        @(negedge clk); chk(2, 1'b0, 2'd3, 16'h0100);   // R2 advances over bubbles
        @(negedge clk); chk(2, 1'b1, 2'd0, 16'h0100);   // R2 wrap to 0
        // Writeback to ctx0 then its own next slot (R5).
        wb_vld = 1; wb_ctx = 2'd0; wb_pc = 16'h0108;
        @(negedge clk); idle_inputs();
        chk(5, 1'b0, 2'd1, 16'h0100);
        repeat (3) @(negedge clk);
        chk(5, 1'b1, 2'd0, 16'h0108);
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

endmodule